// File: doc/BRIEF.md
# Phase-Shifted Compare Timer

This block derives several waveform outputs from a single time base. A prescaler divides the input clock, and an up-counter runs from zero to a reload value before returning to zero. Every channel compares the counter with its own compare value and works in one of two ways. In toggle mode the channel flips its level once per counter period, at the count that matches its compare value. The result is a square wave at half the wrap rate, and its phase is set by the compare value. In PWM mode the channel gives a duty-cycle waveform.

The compare values and the reload value are double-buffered. Inputs placed on the ports are copied into working registers only when the counter wraps, and also on the first clock after reset. Software or a neighbouring block can therefore move a phase or a period mid-cycle without producing a broken pulse. A per-channel polarity bit inverts the final level.

Top module: `ocm_timer`

## Requirements
- R1: While enabled, the counter advances by one on every (psc+1)-th clock. A PWM channel with compare value k is therefore active for k*(psc+1) clocks of each period.
- R2: The counter climbs from 0 to the working reload value and then returns to 0, so one period lasts (reload+1)*(psc+1) clocks.
- R3: A channel with mode bit 1 (toggle) inverts its internal level only on the clock that ends a prescaled count step whose counter value equals its working compare value. At no other time does the level change.
- R4: In toggle mode the output edges of a channel are spaced by exactly one counter period, so the output frequency is half the wrap rate.
- R5: Toggle channels whose compare values differ by d lag each other by d*(psc+1) clocks.
- R6: A channel with mode bit 0 (PWM) has internal level 1 while counter < compare and level 0 otherwise. Compare 0 keeps it at 0, and a compare above the reload keeps it at 1 for the whole period.
- R7: The cmp and reload inputs reach the working registers only at a wrap (counter at reload on a count step) or on the first clock after reset. Changes at any other time do not affect the current period.
- R8: Output bit i equals the internal level XOR pol[i]. pol=0 passes the level and pol=1 inverts it, and the inversion applies without delay.
- R9: While en is 0, the counter, the prescaler and the toggle levels hold their values.
- R10: Reset drives every internal level to 0, so after reset each output equals its pol bit.
- R11: A toggle channel whose working compare value is above the working reload never changes level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Run enable for prescaler and counter |
| psc | input | PW | Prescale divisor minus one |
| reload | input | CW | Counter top value (shadowed) |
| cmp | input | NCH*CW | Compare values, channel i at bits i*CW +: CW (shadowed) |
| mode | input | NCH | Per channel: 1 toggle, 0 PWM |
| pol | input | NCH | Per channel: 1 inverts the output |
| wave | output | NCH | Channel outputs |

## Verification
The hardest state to reach from the ports is a new reload or compare value arriving in the middle of a period, where the old value must stay in force until the wrap. The bench synchronises to an observed toggle edge, changes the reload there, and measures the spacing of the next two edges, which must be the old period and then the new one. Random rounds also change compare values at arbitrary counter positions while en drops at random. A cycle-level model of the requirements checks every output sample during these rounds.

// File: rtl/ocm_timer.sv
module ocm_timer #(
  parameter int NCH = 4,
  parameter int CW  = 16,
  parameter int PW  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [PW-1:0]     psc,
  input  logic [CW-1:0]     reload,
  input  logic [NCH*CW-1:0] cmp,
  input  logic [NCH-1:0]    mode,
  input  logic [NCH-1:0]    pol,
  output logic [NCH-1:0]    wave
);

  logic [PW-1:0]          pre;
  logic [CW-1:0]          cnt, rl_a;
  logic [NCH-1:0][CW-1:0] cmp_a;
  logic [NCH-1:0]         tq, hit, lvl;
  logic                   init, tick, wrap;

  assign tick = en && !init && (pre >= psc);
  assign wrap = tick && (cnt >= rl_a);

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    assign hit[i]  = tick && mode[i] && (cnt == cmp_a[i]);
    assign lvl[i]  = mode[i] ? tq[i] : (cnt < cmp_a[i]);
    assign wave[i] = lvl[i] ^ pol[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre   <= '0;
      cnt   <= '0;
      rl_a  <= '0;
      cmp_a <= '0;
      tq    <= '0;
      init  <= 1'b1;
    end else begin
      init <= 1'b0;
      if (init || wrap) begin
        rl_a <= reload;
        for (int i = 0; i < NCH; i++) cmp_a[i] <= cmp[i*CW +: CW];
      end
      if (tick) begin
        pre <= '0;
        cnt <= wrap ? '0 : cnt + 1'b1;
      end else if (en && !init) begin
        pre <= pre + 1'b1;
      end
      tq <= tq ^ hit;
    end
  end

endmodule

// File: rtl/ocm_timer_chk.sv
module ocm_timer_chk #(
  parameter int NCH = 4,
  parameter int CW  = 16,
  parameter int PW  = 16
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   en,
  input logic [PW-1:0]          psc,
  input logic [PW-1:0]          pre,
  input logic [CW-1:0]          cnt,
  input logic [CW-1:0]          rl_a,
  input logic [NCH-1:0][CW-1:0] cmp_a,
  input logic [NCH-1:0]         tq,
  input logic                   init
);

  // R2
  cnt_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= rl_a);

  // R1
  pre_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !init && pre < psc) |=> (pre == $past(pre) + 1'b1));

  // R3
  toggle_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (init || !en || pre < psc) |=> $stable(tq));

  // R7
  shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!init && !(en && pre >= psc && cnt >= rl_a)) |=> ($stable(rl_a) && $stable(cmp_a)));

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !init) |=> ($stable(cnt) && $stable(pre)));

  for (genvar i = 0; i < NCH; i++) begin : g_far
    // R11
    far_cmp_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmp_a[i] > rl_a) |=> $stable(tq[i]));
  end

endmodule

bind ocm_timer ocm_timer_chk #(.NCH(NCH), .CW(CW), .PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .psc(psc), .pre(pre), .cnt(cnt),
  .rl_a(rl_a), .cmp_a(cmp_a), .tq(tq), .init(init)
);

// File: tb/ocm_timer_bench.sv
`timescale 1ns/1ps
module ocm_timer_bench;
  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            en = 1'b0;
  logic [15:0]     psc = '0;
  logic [15:0]     reload = '0;
  logic [3:0][15:0] cmpv = '0;
  logic [3:0]      mode = '0;
  logic [3:0]      pol = '0;
  logic [3:0]      wave;

  ocm_timer u_ocm_timer (
    .clk(clk), .rst_n(rst_n), .en(en), .psc(psc), .reload(reload),
    .cmp(cmpv), .mode(mode), .pol(pol), .wave(wave)
  );

  always #10 clk = ~clk;

  int errors = 0, checks = 0, cyc = 0;
  bit done = 1'b0;
  int m_pre, m_cnt, m_rl;
  int m_cmp[4];
  bit [3:0] m_tq;
  bit m_init;
  int last_e[4], prev_e[4], ecount[4];
  logic [3:0] prev_w;

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] exp_wave();
    logic [3:0] w;
    for (int i = 0; i < 4; i++)
      w[i] = (mode[i] ? m_tq[i] : (m_cnt < m_cmp[i])) ^ pol[i];
    return w;
  endfunction

  task automatic model_edge();
    if (m_init) begin
      m_init = 0;
      m_rl = reload;
      for (int i = 0; i < 4; i++) m_cmp[i] = cmpv[i];
    end else if (en) begin
      if (m_pre >= int'(psc)) begin
        m_pre = 0;
        for (int i = 0; i < 4; i++)
          if (mode[i] && m_cnt == m_cmp[i]) m_tq[i] = ~m_tq[i];
        if (m_cnt >= m_rl) begin
          m_cnt = 0;
          m_rl = reload;
          for (int i = 0; i < 4; i++) m_cmp[i] = cmpv[i];
        end else m_cnt++;
      end else m_pre++;
    end
  endtask

  task automatic step();
    logic [3:0] e;
    @(posedge clk);
    model_edge();
    cyc++;
    @(negedge clk);
    e = exp_wave();
    chk(wave === e, "R3/R6 model", int'(wave), int'(e));
    for (int i = 0; i < 4; i++)
      if (wave[i] !== prev_w[i]) begin
        prev_e[i] = last_e[i];
        last_e[i] = cyc;
        ecount[i]++;
      end
    prev_w = wave;
  endtask

  task automatic run(int n);
    for (int k = 0; k < n; k++) step();
  endtask

  task automatic clr_edges();
    for (int i = 0; i < 4; i++) ecount[i] = 0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    m_pre = 0; m_cnt = 0; m_rl = 0; m_tq = '0; m_init = 1;
    for (int i = 0; i < 4; i++) m_cmp[i] = 0;
    // R10: outputs equal polarity bits while reset holds
    chk(wave === pol, "R10 reset level", int'(wave), int'(pol));
    prev_w = wave;
    rst_n = 1'b1;
  endtask

  task automatic wait_change(int ch);
    int k = 0;
    logic v = wave[ch];
    while (wave[ch] === v && k < 500) begin step(); k++; end
  endtask

  initial begin
    int t0, d1, d2, h;
    logic [3:0] snap;
    void'($urandom(32'd20240611));
    pol = 4'b0101; mode = 4'b0011;
    do_reset();

    // R1, R2: PWM duty and period with psc=2, reload=9, cmp=3
    psc = 2; reload = 9; cmpv = '0; cmpv[0] = 3; mode = 4'b0000; pol = 4'b0000; en = 1;
    do_reset();
    run(5);
    wait_change(0);
    if (wave[0] !== 1'b1) wait_change(0);
    h = 0; do begin step(); h++; end while (wave[0] === 1'b1 && h < 200);
    chk(h == 9, "R1 active span", h, 9);
    h = 0; do begin step(); h++; end while (wave[0] === 1'b0 && h < 200);
    chk(h == 21, "R2 inactive span", h, 21);

    // R3, R4, R5: toggle phases 0,2,4,6 at psc=1 reload=9
    psc = 1; reload = 9; mode = 4'hF;
    cmpv[0] = 0; cmpv[1] = 2; cmpv[2] = 4; cmpv[3] = 6;
    run(60);
    clr_edges();
    run(80);
    for (int i = 0; i < 4; i++) begin
      chk(ecount[i] == 4, "R3 edges per window", ecount[i], 4);
      chk(last_e[i] - prev_e[i] == 20, "R4 edge spacing", last_e[i] - prev_e[i], 20);
      chk((((last_e[i] - last_e[0]) % 20) + 20) % 20 == 4 * i, "R5 phase lag",
          (((last_e[i] - last_e[0]) % 20) + 20) % 20, 4 * i);
    end

    // R6, R11: far compare values and zero compare
    cmpv[3] = 15; cmpv[2] = 12; cmpv[1] = 0; mode = 4'b1001;
    run(45);
    clr_edges();
    run(60);
    chk(ecount[3] == 0, "R11 far toggle quiet", ecount[3], 0);
    chk(ecount[2] == 0 && wave[2] === 1'b1, "R6 far PWM active", int'(wave[2]), 1);
    chk(ecount[1] == 0 && wave[1] === 1'b0, "R6 zero PWM inactive", int'(wave[1]), 0);
    chk(ecount[0] == 3, "R4 toggle count", ecount[0], 3);

    // R7: reload change mid-period takes effect at wrap
    mode = 4'b0001; cmpv[0] = 0;
    run(30);
    wait_change(0);
    reload = 4;
    t0 = cyc; wait_change(0); d1 = cyc - t0;
    t0 = cyc; wait_change(0); d2 = cyc - t0;
    chk(d1 == 20, "R7 old period kept", d1, 20);
    chk(d2 == 10, "R7 new period", d2, 10);

    // R9: disabled hold
    mode = 4'b0101; cmpv[2] = 3;
    run(23);
    en = 0; snap = wave; clr_edges();
    run(30);
    chk(ecount[0] + ecount[1] + ecount[2] + ecount[3] == 0, "R9 hold edges",
        ecount[0] + ecount[1] + ecount[2] + ecount[3], 0);
    chk(wave === snap, "R9 hold value", int'(wave), int'(snap));

    // R8: polarity flips immediately
    pol = 4'b1111; #1;
    chk(wave === ~snap, "R8 polarity", int'(wave), int'(~snap));
    step();
    pol = 4'b0110;
    en = 1;
    run(40);

    // Random rounds
    for (int r = 0; r < 5; r++) begin
      psc = 16'($urandom_range(0, 3));
      reload = 16'($urandom_range(3, 20));
      for (int i = 0; i < 4; i++) cmpv[i] = 16'($urandom_range(0, 24));
      mode = 4'($urandom); pol = 4'($urandom);
      if (r == 2) begin pol = 4'b1010; do_reset(); end
      for (int k = 0; k < 300; k++) begin
        if (k % 37 == 5) cmpv[$urandom_range(0, 3)] = 16'($urandom_range(0, 24));
        if (k % 91 == 50) reload = 16'($urandom_range(3, 20));
        en = ($urandom_range(0, 7) != 0);
        step();
      end
      en = 1;
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule